// File: doc/BRIEF.md
# Bitwise Logic Microoperation Unit

This block holds an accumulator register A and combines it, bit by bit, with an operand B presented on its input. A 4-bit function code selects any one of the sixteen Boolean functions of two inputs. When the enable is high on a rising clock edge, the result is written back into A. The function code is the truth-table column of the chosen function. Each bit of the result is the code bit indexed by the pair {A bit, B bit}. Common uses fall out of particular codes: setting, complementing or clearing selected bits of A, or masking A down to a field.

A second mode loads a new value into a bit field of A, with the rest of A kept. It takes two fixed cycles. On the first edge, A is ANDed with B, which then carries a keep mask. On the very next edge, A is ORed with B, which by then carries the bits to insert. A registered zero flag is updated together with A and tells whether the new A is all zeros. The data width is a parameter with a default of 8 bits.

Top module: `lmu_core`

## Requirements
- R1: While reset is high, the next rising edge clears A to all zeros and sets the zero flag to 1.
- R2: When enable is high and insert is low outside an insert sequence, each bit i of the new A equals fcode[2*A[i] + B[i]]. Code 0 yields all zeros and code 15 yields all ones. Code 10 copies B into A and code 12 leaves A unchanged.
- R3: When enable and insert are both low outside an insert sequence, A and the zero flag keep their values.
- R4: Code 14 (selective set, A OR B) turns A=0000_1010 with B=0000_1100 into 0000_1110.
- R5: Code 6 (selective complement, A XOR B) turns 0000_1010 with 0000_1100 into 0000_0110. The same code applied to two equal values gives all zeros, and the zero flag reads 1.
- R6: Code 4 (selective clear, A AND NOT B) turns 0000_1010 with 0000_1100 into 0000_0010.
- R7: Code 8 (mask, A AND B) turns 0000_1010 with 0000_1100 into 0000_1000.
- R8: When enable and insert are both high outside an insert sequence, the edge writes A AND B. The following edge writes A OR B, with B sampled at that second edge. For example, 0110_1010 with mask 0000_1111 gives 0000_1010, and inserting 1001_0000 then gives 1001_1010.
- R9: On the second edge of an insert sequence, enable, insert and the function code have no effect. The OR step happens regardless, and the unit is then ready for a new operation.
- R10: After every edge out of reset, the zero flag is 1 exactly when A is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Write enable for an operation |
| ins | input | 1 | With en, starts the two-cycle field insert |
| fcode | input | 4 | Truth-table column of the bitwise function |
| opnd_b | input | W | Operand B (the mask, then the insert bits, during an insert) |
| acc_a | output | W | Accumulator register A |
| zero | output | 1 | High when A is all zeros |

## Verification
An ordinary function request can land on the same edge as the OR step of an insert sequence. The user holds enable and insert high with some other code, and may even ask for a new insert. The bench provokes this on purpose: it raises enable, insert and codes such as 0 or 15 on the cycle right after an insert starts. It judges the result by A, which must equal the masked value ORed with the B of that cycle, and by a further operation on the next cycle, which must then take effect normally. Random stimulus also starts inserts at random points while enable and the code keep changing. This covers back-to-back inserts and inserts that follow ordinary writes.

// File: rtl/lmu_pkg.sv
package lmu_pkg;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_MERGE = 1'b1
  } lmu_phase_e;

  localparam logic [3:0] FN_AND = 4'd8;
  localparam logic [3:0] FN_OR  = 4'd14;

  // One output bit of the two-input function whose truth-table column is code
  function automatic logic tt_pick(input logic [3:0] code, input logic x, input logic y);
    return code[{x, y}];
  endfunction

endpackage

// File: rtl/lmu_bitslice.sv
module lmu_bitslice #(
  parameter int W = 8
) (
  input  logic [3:0]   code,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] r_out
);
  import lmu_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign r_out[i] = tt_pick(code, a_in[i], b_in[i]);
  end

endmodule

// File: rtl/lmu_seq.sv
module lmu_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       ins,
  input  logic [3:0] fcode,
  output logic [3:0] eff_code,
  output logic       wr,
  output logic       in_merge
);
  import lmu_pkg::*;

  lmu_phase_e phase_q, phase_d;

  always_comb begin
    phase_d  = phase_q;
    eff_code = fcode;
    wr       = 1'b0;
    case (phase_q)
      PH_MERGE: begin
        eff_code = FN_OR;
        wr       = 1'b1;
        phase_d  = PH_IDLE;
      end
      default: begin
        if (en) begin
          wr = 1'b1;
          if (ins) begin
            eff_code = FN_AND;
            phase_d  = PH_MERGE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  assign in_merge = (phase_q == PH_MERGE);

endmodule

// File: rtl/lmu_acc.sv
module lmu_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] acc,
  output logic         zero
);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      zero <= 1'b1;
    end else if (wr) begin
      acc  <= nxt;
      zero <= (nxt == '0);
    end
  end

endmodule

// File: rtl/lmu_core.sv
module lmu_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         ins,
  input  logic [3:0]   fcode,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] acc_a,
  output logic         zero
);

  logic [3:0]   eff_code;
  logic         wr;
  logic         in_merge;
  logic [W-1:0] result;

  lmu_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .ins      (ins),
    .fcode    (fcode),
    .eff_code (eff_code),
    .wr       (wr),
    .in_merge (in_merge)
  );

  lmu_bitslice #(.W(W)) u_slice (
    .code  (eff_code),
    .a_in  (acc_a),
    .b_in  (opnd_b),
    .r_out (result)
  );

  lmu_acc #(.W(W)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .wr   (wr),
    .nxt  (result),
    .acc  (acc_a),
    .zero (zero)
  );

endmodule

// File: rtl/lmu_core_chk.sv
module lmu_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         ins,
  input logic [3:0]   fcode,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] acc_a,
  input logic         zero,
  input logic         in_merge
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_a == '0) && zero);

  // R2
  const_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_merge && en && !ins && fcode == 4'd0) |=> (acc_a == '0));

  // R2
  const_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_merge && en && !ins && fcode == 4'd15) |=> (acc_a == '1));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_merge && !en && !ins) |=> ($stable(acc_a) && $stable(zero)));

  // R8
  ins_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_merge && en && ins) |=> (in_merge && acc_a == ($past(acc_a) & $past(opnd_b))));

  // R9
  ins_merge_chk: assert property (@(posedge clk) disable iff (rst)
    in_merge |=> (!in_merge && acc_a == ($past(acc_a) | $past(opnd_b))));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    zero == (acc_a == '0));

endmodule

bind lmu_core lmu_core_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .ins      (ins),
  .fcode    (fcode),
  .opnd_b   (opnd_b),
  .acc_a    (acc_a),
  .zero     (zero),
  .in_merge (in_merge)
);

// File: tb/lmu_core_test.sv
module lmu_core_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         ins = 1'b0;
  logic [3:0]   fcode = 4'd0;
  logic [W-1:0] opnd_b = '0;
  logic [W-1:0] acc_a;
  logic         zero;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_a = '0;
  logic         m_merge = 1'b0;

  always #2 clk = ~clk;

  lmu_core #(.W(W)) uut (
    .clk(clk), .rst(rst), .en(en), .ins(ins), .fcode(fcode),
    .opnd_b(opnd_b), .acc_a(acc_a), .zero(zero)
  );

  function automatic logic [W-1:0] fn_model(input logic [3:0] c, input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = c[{a[i], b[i]}];
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s acc_a=%h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_zero(input string tag);
    checks++;
    if (zero !== (m_a == '0)) begin
      errors++;
      $display("FAIL %s zero=%b expected %b", tag, zero, (m_a == '0));
    end
  endtask

  task automatic step(input logic e, input logic i, input logic [3:0] c, input logic [W-1:0] b);
    @(negedge clk);
    en = e; ins = i; fcode = c; opnd_b = b;
    @(posedge clk);
    if (m_merge) begin
      m_a = m_a | b;
      m_merge = 1'b0;
    end else if (e) begin
      if (i) begin
        m_a = m_a & b;
        m_merge = 1'b1;
      end else begin
        m_a = fn_model(c, m_a, b);
      end
    end
    #1;
  endtask

  task automatic op_pair(input string tag, input logic [3:0] c, input logic [W-1:0] a0,
                         input logic [W-1:0] b, input logic [W-1:0] exp);
    step(1'b1, 1'b0, 4'd10, a0);
    step(1'b1, 1'b0, c, b);
    check(tag, acc_a, exp);
    check(tag, m_a, exp);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", acc_a, '0);
    checks++;
    if (zero !== 1'b1) begin errors++; $display("FAIL R1 zero=%b expected 1", zero); end
    @(negedge clk); rst = 1'b0;

    // R4 R5 R6 R7 named examples
    op_pair("R4", 4'd14, 8'h0A, 8'h0C, 8'h0E);
    op_pair("R5", 4'd6,  8'h0A, 8'h0C, 8'h06);
    op_pair("R6", 4'd4,  8'h0A, 8'h0C, 8'h02);
    op_pair("R7", 4'd8,  8'h0A, 8'h0C, 8'h08);
    op_pair("R5", 4'd6,  8'h5C, 8'h5C, 8'h00);
    check_zero("R5");

    // R2 constants, transfer and identity
    step(1'b1, 1'b0, 4'd15, 8'h33); check("R2", acc_a, 8'hFF);
    check_zero("R10");
    step(1'b1, 1'b0, 4'd12, 8'h00); check("R2", acc_a, 8'hFF);
    step(1'b1, 1'b0, 4'd0, 8'hA5);  check("R2", acc_a, 8'h00);
    step(1'b1, 1'b0, 4'd10, 8'hC3); check("R2", acc_a, 8'hC3);

    // R3 hold with enable low while code and B change
    step(1'b0, 1'b0, 4'd0, 8'h00);  check("R3", acc_a, 8'hC3);
    step(1'b0, 1'b0, 4'd15, 8'hFF); check("R3", acc_a, 8'hC3);
    check_zero("R3");

    // R8 field insert example
    step(1'b1, 1'b0, 4'd10, 8'h6A);
    step(1'b1, 1'b1, 4'd3, 8'h0F);  check("R8", acc_a, 8'h0A);
    step(1'b0, 1'b0, 4'd0, 8'h90);  check("R8", acc_a, 8'h9A);

    // R9 conflicting request on the merge edge
    step(1'b1, 1'b1, 4'd10, 8'h0F); check("R8", acc_a, 8'h0A);
    step(1'b1, 1'b1, 4'd0, 8'h40);  check("R9", acc_a, 8'h4A);
    step(1'b1, 1'b0, 4'd15, 8'h00); check("R9", acc_a, 8'hFF);
    step(1'b1, 1'b1, 4'd0, 8'h00);  check("R8", acc_a, 8'h00);
    check_zero("R10");
    step(1'b1, 1'b0, 4'd15, 8'h00); check("R9", acc_a, 8'h00);
    check_zero("R9");

    // R2 R8 R9 R10 random mix
    for (int k = 0; k < 400; k++) begin
      step(($urandom % 4) != 0, ($urandom % 5) == 0, 4'($urandom), W'($urandom));
      check("R2", acc_a, m_a);
      check_zero("R10");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule